// File: doc/BRIEF.md
# Short Branch Resolution Unit

This unit settles self-relative short control transfers for a 16-bit processor core. Each request carries an operation kind, a four-bit condition code, the five status flags (carry, zero, sign, overflow, parity), the address of the following instruction, a signed 8-bit displacement and the current loop count. The unit decides whether the transfer is taken. One clock later it presents the next instruction pointer, a one-cycle redirect pulse for the fetch stage, and, for counted loops, the decremented count with a write enable.

A conditional jump tests one of sixteen conditions. The unsigned comparisons use carry and zero. The signed comparisons use sign, overflow and zero. Four single-flag tests cover overflow, zero, sign and parity. Bit 0 of the condition code gives the complement of the test named by bits 3:1. The counted-loop operation decrements the count and branches while the result is nonzero. The count-zero jump branches only when the count is already zero. A taken transfer lands at the next-instruction address plus the sign-extended displacement, wrapping modulo 2^16. That gives a reach of -128 to +127 bytes.

Top module: `sbr_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `res_valid`, `redirect` and `cx_we` are 0 after that edge.
- R2: With `req_op`=0 (conditional jump), the unsigned codes resolve as follows: 2 is taken when CF=1, 3 when CF=0, 6 when (CF or ZF)=1, and 7 when CF=0 and ZF=0.
- R3: With `req_op`=0, the signed codes resolve as follows: 12 is taken when (SF xor OF)=1, 13 when it is 0, 14 when ((SF xor OF) or ZF)=1, and 15 when that expression is 0.
- R4: With `req_op`=0, the single-flag codes resolve as follows: 0/1 are taken on OF=1/OF=0, 4/5 on ZF=1/ZF=0, 8/9 on SF=1/SF=0, and 10/11 on PF=1/PF=0.
- R5: When a request is taken, `next_ptr` one cycle later equals (`next_ip` + sign-extended `disp`) mod 2^16.
- R6: When a valid request is not taken, `next_ptr` one cycle later equals `next_ip` and `redirect` is 0. A conditional jump never asserts `cx_we`.
- R7: With `req_op`=1 (counted loop), one cycle later `cx_we`=1 and `cx_out`=(`cx_in`-1) mod 2^16. The branch is taken only if that new count is nonzero. A count of 1 is not taken, and a count of 0 wraps to FFFF and is taken.
- R8: With `req_op`=2 (jump if count zero), the branch is taken only when `cx_in`=0, and `cx_we` stays 0.
- R9: `redirect` is 1 for exactly the one cycle after a valid taken request. A cycle with `req_valid`=0 yields `res_valid`=0, `redirect`=0 and `cx_we`=0 on the next cycle.
- R10: `req_op`=3 is reserved. It is never taken and never writes the count, and `next_ptr` equals `next_ip`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 conditional, 1 counted loop, 2 jump if count zero, 3 reserved |
| cond_sel | input | 4 | Condition code for conditional jumps |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| flag_pf | input | 1 | Parity flag |
| next_ip | input | 16 | Address of the following instruction |
| disp | input | 8 | Signed displacement |
| cx_in | input | 16 | Current loop count |
| res_valid | output | 1 | Registered result present |
| redirect | output | 1 | One-cycle redirect pulse to fetch |
| next_ptr | output | 16 | Resolved next instruction pointer |
| cx_we | output | 1 | Loop count write enable |
| cx_out | output | 16 | Decremented loop count |

## Verification
Every condition code is tried against flag patterns chosen so that each pair of codes differs. Carry alone, zero alone, and both together separate "above" from "above or equal". Sign and overflow in agreement and in disagreement, each with and without zero, separate "greater" from "greater or equal". Targets are exercised with positive and negative displacements and with wraps past both ends of the address space. Loop counts of 0, 1 and 2 separate the wrap case, the exit case and the normal branch. Idle cycles, back-to-back requests and the reserved operation show that the redirect pulse is one cycle wide and that the count is not written when it should not be.

// File: rtl/sbr_pkg.sv
// Shared widths and operation encoding for the short branch resolution unit.
package sbr_pkg;
    localparam int IP_W   = 16;
    localparam int DISP_W = 8;
    localparam int CX_W   = 16;
    localparam int SEL_W  = 4;

    typedef enum logic [1:0] {
        OP_JCC  = 2'd0,
        OP_LOOP = 2'd1,
        OP_JCXZ = 2'd2,
        OP_RSVD = 2'd3
    } sbr_op_e;
endpackage

// File: rtl/sbr_cond_eval.sv
// Condition evaluator: maps a 4-bit condition code and the status flags to a
// taken decision. Bits 3:1 pick the test and bit 0 complements it.
// Assumes the flags are stable for the cycle in which the request is valid.
module sbr_cond_eval (
    input  logic [3:0] sel,
    input  logic       cf,
    input  logic       zf,
    input  logic       sf,
    input  logic       of,
    input  logic       pf,
    output logic       taken
);
    logic base;

    // Select the base test named by the upper three bits.
    always_comb begin
        unique case (sel[3:1])
            3'd0: base = of;
            3'd1: base = cf;
            3'd2: base = zf;
            3'd3: base = cf | zf;
            3'd4: base = sf;
            3'd5: base = pf;
            3'd6: base = sf ^ of;
            default: base = (sf ^ of) | zf;
        endcase
        taken = base ^ sel[0];
    end

    // Spot checks on the unsigned and signed families against the raw flags.
    always_comb begin
        if (sel == 4'h7 && (cf || zf))
            assert_above_needs_clear_R2: assert (!taken);
        if (sel == 4'hD && (sf != of))
            assert_ge_needs_match_R3: assert (!taken);
    end
endmodule

// File: rtl/sbr_loop_ctl.sv
// Loop count control: computes the decremented count and the taken decisions
// for the counted loop and the count-zero jump. Assumes cx_in is the count
// value before the instruction executes.
module sbr_loop_ctl #(
    parameter int CX_W = 16
) (
    input  logic [CX_W-1:0] cx_in,
    output logic [CX_W-1:0] cx_dec,
    output logic            loop_take,
    output logic            zero_take
);
    // Decrement and test the count.
    always_comb begin
        cx_dec    = cx_in - CX_W'(1);
        loop_take = (cx_dec != '0);
        zero_take = (cx_in == '0);
    end
endmodule

// File: rtl/sbr_target.sv
// Target adder: sign-extends the displacement and adds it to the address of
// the following instruction. The result wraps modulo 2^IP_W.
module sbr_target #(
    parameter int IP_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic [IP_W-1:0]   base_ip,
    input  logic [DISP_W-1:0] disp,
    output logic [IP_W-1:0]   target
);
    localparam int EXT_W = IP_W - DISP_W;

    // Sign-extend and add.
    always_comb begin
        target = base_ip + {{EXT_W{disp[DISP_W-1]}}, disp};
    end
endmodule

// File: rtl/sbr_unit.sv
// Short branch resolution unit: resolves conditional jumps, counted loops and
// count-zero jumps, and registers the next pointer, the redirect pulse and the
// count write-back. Results appear one cycle after req_valid.
// Assumes all request inputs are valid in the same cycle as req_valid.
module sbr_unit #(
    parameter int IP_W   = sbr_pkg::IP_W,
    parameter int DISP_W = sbr_pkg::DISP_W,
    parameter int CX_W   = sbr_pkg::CX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [3:0]        cond_sel,
    input  logic              flag_cf,
    input  logic              flag_zf,
    input  logic              flag_sf,
    input  logic              flag_of,
    input  logic              flag_pf,
    input  logic [IP_W-1:0]   next_ip,
    input  logic [DISP_W-1:0] disp,
    input  logic [CX_W-1:0]   cx_in,
    output logic              res_valid,
    output logic              redirect,
    output logic [IP_W-1:0]   next_ptr,
    output logic              cx_we,
    output logic [CX_W-1:0]   cx_out
);
    import sbr_pkg::*;

    sbr_op_e         op;
    logic            cond_take;
    logic            loop_take;
    logic            zero_take;
    logic [CX_W-1:0] cx_dec;
    logic [IP_W-1:0] target;
    logic            take;

    assign op = sbr_op_e'(req_op);

    sbr_cond_eval u_cond (
        .sel   (cond_sel),
        .cf    (flag_cf),
        .zf    (flag_zf),
        .sf    (flag_sf),
        .of    (flag_of),
        .pf    (flag_pf),
        .taken (cond_take)
    );

    sbr_loop_ctl #(.CX_W(CX_W)) u_loop (
        .cx_in     (cx_in),
        .cx_dec    (cx_dec),
        .loop_take (loop_take),
        .zero_take (zero_take)
    );

    sbr_target #(.IP_W(IP_W), .DISP_W(DISP_W)) u_tgt (
        .base_ip (next_ip),
        .disp    (disp),
        .target  (target)
    );

    // Pick the taken decision for the current operation kind.
    always_comb begin
        unique case (op)
            OP_JCC:  take = cond_take;
            OP_LOOP: take = loop_take;
            OP_JCXZ: take = zero_take;
            default: take = 1'b0;
        endcase
    end

    // Register the result, the redirect pulse and the count write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            redirect  <= 1'b0;
            next_ptr  <= '0;
            cx_we     <= 1'b0;
            cx_out    <= '0;
        end else begin
            res_valid <= req_valid;
            redirect  <= req_valid && take;
            next_ptr  <= take ? target : next_ip;
            cx_we     <= req_valid && (op == OP_LOOP);
            cx_out    <= cx_dec;
        end
    end

    // A redirect only follows a request in the previous cycle.
    assert_redirect_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> $past(req_valid));

    // Idle cycles produce no result.
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && !redirect && !cx_we));

    // The count is written only for a counted loop.
    assert_cx_write_only_loop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cx_we |-> $past(req_valid && req_op == 2'd1));

    // The written count is one less than the count presented.
    assert_loop_decrements_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cx_we |-> (cx_out == $past(cx_in) - CX_W'(1)));

    // A completed loop with a zero result does not redirect.
    assert_loop_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cx_we && cx_out == '0) |-> !redirect);

    // A result without redirect points to the following instruction.
    assert_not_taken_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !redirect) |-> (next_ptr == $past(next_ip)));

    // The reserved operation never redirects.
    assert_reserved_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3) |=> !redirect);
endmodule

// File: tb/sbr_unit_test.sv
// Directed bench for the short branch resolution unit.
module sbr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [3:0]  cond_sel = 4'd0;
    logic        flag_cf = 0, flag_zf = 0, flag_sf = 0, flag_of = 0, flag_pf = 0;
    logic [15:0] next_ip = 16'h0;
    logic [7:0]  disp = 8'h0;
    logic [15:0] cx_in = 16'h0;
    logic        res_valid, redirect, cx_we;
    logic [15:0] next_ptr, cx_out;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    sbr_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .cond_sel(cond_sel), .flag_cf(flag_cf), .flag_zf(flag_zf),
        .flag_sf(flag_sf), .flag_of(flag_of), .flag_pf(flag_pf),
        .next_ip(next_ip), .disp(disp), .cx_in(cx_in),
        .res_valid(res_valid), .redirect(redirect), .next_ptr(next_ptr),
        .cx_we(cx_we), .cx_out(cx_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Independent condition model written from R2, R3, R4.
    function automatic logic model_cond(input logic [3:0] s, input logic [4:0] f);
        logic cf, zf, sf, of, pf;
        {cf, zf, sf, of, pf} = f;
        case (s)
            4'h0: return of;        4'h1: return !of;
            4'h2: return cf;        4'h3: return !cf;
            4'h4: return zf;        4'h5: return !zf;
            4'h6: return cf || zf;  4'h7: return !cf && !zf;
            4'h8: return sf;        4'h9: return !sf;
            4'hA: return pf;        4'hB: return !pf;
            4'hC: return sf != of;  4'hD: return sf == of;
            4'hE: return (sf != of) || zf;
            default: return (sf == of) && !zf;
        endcase
    endfunction

    // Drive one request for one cycle, then leave the bus idle; results are
    // sampled at the following falling edge.
    task automatic issue(input logic [1:0] op, input logic [3:0] s, input logic [4:0] f,
                         input logic [15:0] ip, input logic [7:0] d, input logic [15:0] cx);
        req_valid = 1'b1; req_op = op; cond_sel = s;
        {flag_cf, flag_zf, flag_sf, flag_of, flag_pf} = f;
        next_ip = ip; disp = d; cx_in = cx;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [15:0] tgt(input logic [15:0] ip, input logic [7:0] d);
        return ip + {{8{d[7]}}, d};
    endfunction

    task automatic cond_family(input string req, input logic [3:0] lo, input logic [3:0] hi);
        logic [4:0] pats [6] = '{5'b00000, 5'b10000, 5'b01000, 5'b11000, 5'b00110, 5'b01101};
        for (int p = 0; p < 6; p++) begin
            for (int s = lo; s <= hi; s++) begin
                logic e;
                e = model_cond(4'(s), pats[p]);
                issue(2'd0, 4'(s), pats[p], 16'h1200, 8'h10, 16'h5);
                check(req, {30'd0, redirect, cx_we}, {30'd0, e, 1'b0});
                check(req, {16'd0, next_ptr}, {16'd0, e ? 16'h1210 : 16'h1200});
            end
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R1", {29'd0, res_valid, redirect, cx_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_unsigned();
        cond_family("R2", 4'h2, 4'h3);
        cond_family("R2", 4'h6, 4'h7);
    endtask

    task automatic test_signed();
        logic [4:0] sp [4] = '{5'b00110, 5'b00100, 5'b00010, 5'b01110};
        cond_family("R3", 4'hC, 4'hF);
        for (int p = 0; p < 4; p++) begin
            issue(2'd0, 4'hF, sp[p], 16'h0100, 8'h02, 16'h0);
            check("R3", {31'd0, redirect}, {31'd0, model_cond(4'hF, sp[p])});
        end
    endtask

    task automatic test_single();
        cond_family("R4", 4'h0, 4'h1);
        cond_family("R4", 4'h4, 4'h5);
        cond_family("R4", 4'h8, 4'hB);
    endtask

    task automatic test_target();
        logic [15:0] ips [4] = '{16'h1000, 16'h1000, 16'hFFF0, 16'h0010};
        logic [7:0]  ds  [4] = '{8'h7F, 8'h80, 8'h20, 8'hE0};
        for (int i = 0; i < 4; i++) begin
            issue(2'd0, 4'h3, 5'b00000, ips[i], ds[i], 16'h0);
            check("R5", {15'd0, redirect, next_ptr}, {15'd0, 1'b1, tgt(ips[i], ds[i])});
        end
    endtask

    task automatic test_not_taken();
        issue(2'd0, 4'h2, 5'b00000, 16'hABCD, 8'h40, 16'h3);
        check("R6", {14'd0, res_valid, redirect, next_ptr}, {14'd0, 1'b1, 1'b0, 16'hABCD});
        check("R6", {31'd0, cx_we}, 32'd0);
    endtask

    task automatic test_loop();
        logic [15:0] cxs [3] = '{16'd2, 16'd1, 16'd0};
        logic        tk  [3] = '{1'b1, 1'b0, 1'b1};
        for (int i = 0; i < 3; i++) begin
            issue(2'd1, 4'h0, 5'b11111, 16'h2000, 8'hF0, cxs[i]);
            check("R7", {14'd0, cx_we, redirect, cx_out}, {14'd0, 1'b1, tk[i], cxs[i] - 16'd1});
            check("R7", {16'd0, next_ptr}, {16'd0, tk[i] ? 16'h1FF0 : 16'h2000});
        end
    endtask

    task automatic test_jcxz();
        issue(2'd2, 4'h0, 5'b00000, 16'h3000, 8'h05, 16'd0);
        check("R8", {14'd0, redirect, cx_we, next_ptr}, {14'd0, 1'b1, 1'b0, 16'h3005});
        issue(2'd2, 4'h0, 5'b01000, 16'h3000, 8'h05, 16'd1);
        check("R8", {14'd0, redirect, cx_we, next_ptr}, {14'd0, 1'b0, 1'b0, 16'h3000});
    endtask

    task automatic test_pulse();
        issue(2'd0, 4'h4, 5'b01000, 16'h4000, 8'h08, 16'd0);
        check("R9", {31'd0, redirect}, 32'd1);
        @(negedge clk);
        check("R9", {29'd0, res_valid, redirect, cx_we}, 32'd0);
        issue(2'd1, 4'h0, 5'b00000, 16'h4000, 8'h08, 16'd9);
        @(negedge clk);
        check("R9", {29'd0, res_valid, redirect, cx_we}, 32'd0);
    endtask

    task automatic test_reserved();
        for (int s = 0; s < 16; s += 5) begin
            issue(2'd3, 4'(s), 5'b11111, 16'h5555, 8'h33, 16'd0);
            check("R10", {14'd0, redirect, cx_we, next_ptr}, {14'd0, 1'b0, 1'b0, 16'h5555});
        end
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        test_unsigned();
        test_signed();
        test_single();
        test_target();
        test_not_taken();
        test_loop();
        test_jcxz();
        test_pulse();
        test_reserved();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule